// File: doc/BRIEF.md
# Shared Active-Low Line Ownership Controller

This block governs a single active-low line that a set of agents share, one driver at a time. An external arbiter names the next owner through a claim channel. The current owner then asks to pull the line low or to give it up. The controller produces an output-enable and a drive value for every agent, and a resolved line level that reads high whenever nobody drives, as a pull-up would make it.

Hand-over follows a fixed sequence. An owner that has been driving low is made to drive high for one clock before its enable drops. After the enable drops there is one clock in which nobody drives the line. Only after that clock may a new owner start driving. A new owner starts out driving high. The controller ignores requests that would break these rules and reports them on one-cycle error pulses.

The claim channel uses a valid/ready handshake. A claim is taken on a clock edge where `claim_valid` and `claim_ready` are both high. `claim_ready` is high only while nobody owns the line: when idle, and during the mandatory undriven clock. A claim offered while `claim_ready` is low is not remembered, so the arbiter must keep `claim_valid` and `claim_id` up until the handshake completes. The other inputs are plain per-agent levels, sampled on every rising edge.

Top module: `sts_owner_ctl`

## Requirements
- R1: After reset, all output-enables are low, the line reads high, `claim_ready` is high and every error output is low.
- R2: A claim accepted on an edge makes exactly the claimed agent's output-enable high from that edge, driving high in its first owned cycle.
- R3: While the owner holds the line and does not release it, the line is low in the cycle after an edge where the owner's bit of `assert_req` was 1, and high in the cycle after an edge where that bit was 0.
- R4: A release sampled while the owner drives low gives one cycle of that owner driving high, and then all enables go low.
- R5: A release sampled while the owner drives high drops all enables in the next cycle.
- R6: Between two owners there is at least one cycle with every enable low, and the enabled agent never changes from one driven cycle to the next.
- R7: `claim_ready` is low in every cycle where any agent is enabled, and a claim offered then leaves the owner unchanged.
- R8: With no enable high the line reads 1; otherwise it equals the enabled agent's drive value.
- R9: `contention_o` is high only when more than one enable is high, which never happens in correct operation.
- R10: `idle_err_o` pulses for one cycle after an edge where any `assert_req` bit was 1 during the undriven hand-off cycle; such a request does not pull the line low.
- R11: `rogue_err_o` pulses for one cycle after an edge where, outside the undriven hand-off cycle, an agent that was not enabled had its `assert_req` bit at 1; the line is not affected.
- R12: A `release_req` bit from an agent that does not own the line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| claim_valid | input | 1 | Arbiter offers a new owner |
| claim_id | input | ID_W | Index of the offered owner |
| claim_ready | output | 1 | Line free; claim taken when valid is also high |
| assert_req | input | N_AGENTS | Per-agent request to pull the line low |
| release_req | input | N_AGENTS | Per-agent request to give up the line |
| oe_o | output | N_AGENTS | Per-agent output-enable |
| val_o | output | N_AGENTS | Per-agent drive value (1 when not driving low) |
| line_o | output | 1 | Resolved line level with pull-up |
| contention_o | output | 1 | More than one agent enabled |
| idle_err_o | output | 1 | Pulse: low requested during undriven hand-off cycle |
| rogue_err_o | output | 1 | Pulse: low requested by an agent that does not own the line |

## Verification
A corrupted owner register shows up on `oe_o` in the first owned cycle, because the wrong bit is enabled. A lost park cycle shows up in the cycle right after a release from the low level: there the bench expects the enable still high and the line high. A hand-off state that skips the undriven clock shows up at once, because `claim_ready` rises or an enable appears one cycle early. A mis-tracked drive level shows up on `line_o` in the cycle after the request. Every cycle of each scripted sequence is compared, so each of these faults is caught within one clock of its cause.

// File: rtl/sts_pkg.sv
package sts_pkg;
  // Phase of the line hand-over sequence.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // nobody owns the line
    ST_OWN  = 2'd1,  // owner enabled, drive level follows its request
    ST_PARK = 2'd2,  // owner forced high for one clock before floating
    ST_DEAD = 2'd3   // mandatory undriven clock after a release
  } sts_state_e;
endpackage

// File: rtl/sts_hand_fsm.sv
module sts_hand_fsm
  import sts_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           claim_valid,
  input  logic [IDW-1:0] claim_id,
  input  logic [N-1:0]   assert_req,
  input  logic [N-1:0]   release_req,
  output sts_state_e     state,
  output logic [IDW-1:0] owner,
  output logic           drive_low,
  output logic           claim_ready
);
  localparam logic [IDW:0] NUM_AGENTS = (IDW+1)'(N);

  sts_state_e     state_n;
  logic [IDW-1:0] owner_n;
  logic           drive_low_n;
  logic           accept;
  logic           own_assert;
  logic           own_release;

  assign claim_ready = (state == ST_IDLE) || (state == ST_DEAD);
  assign accept      = claim_valid && claim_ready && ({1'b0, claim_id} < NUM_AGENTS);
  assign own_assert  = assert_req[owner];
  assign own_release = release_req[owner];

  always_comb begin
    state_n     = state;
    owner_n     = owner;
    drive_low_n = drive_low;
    unique case (state)
      ST_IDLE, ST_DEAD: begin
        drive_low_n = 1'b0;
        if (accept) begin
          state_n = ST_OWN;
          owner_n = claim_id;
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_OWN: begin
        if (own_release) begin
          state_n     = drive_low ? ST_PARK : ST_DEAD;
          drive_low_n = 1'b0;
        end else begin
          drive_low_n = own_assert;
        end
      end
      ST_PARK: begin
        state_n     = ST_DEAD;
        drive_low_n = 1'b0;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      owner     <= '0;
      drive_low <= 1'b0;
    end else begin
      state     <= state_n;
      owner     <= owner_n;
      drive_low <= drive_low_n;
    end
  end
endmodule

// File: rtl/sts_drive_fanout.sv
module sts_drive_fanout
  import sts_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  sts_state_e     state,
  input  logic [IDW-1:0] owner,
  input  logic           drive_low,
  output logic [N-1:0]   oe,
  output logic [N-1:0]   val
);
  logic holding;
  logic pulling;

  assign holding = (state == ST_OWN) || (state == ST_PARK);
  assign pulling = (state == ST_OWN) && drive_low;

  for (genvar i = 0; i < N; i++) begin : g_agent
    localparam logic [IDW-1:0] MY_ID = IDW'(i);
    assign oe[i]  = holding && (owner == MY_ID);
    assign val[i] = !(pulling && (owner == MY_ID));
  end
endmodule

// File: rtl/sts_line_resolve.sv
module sts_line_resolve #(
  parameter int N = 4
) (
  input  logic [N-1:0] oe,
  input  logic [N-1:0] val,
  output logic         line,
  output logic         contention
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] n_drivers;

  // Pull-up: undriven agents contribute a 1, driven agents their value.
  assign line = &(val | ~oe);

  always_comb begin
    n_drivers = '0;
    for (int k = 0; k < N; k++) begin
      n_drivers = n_drivers + CW'(oe[k]);
    end
  end

  assign contention = (n_drivers > CW'(1));
endmodule

// File: rtl/sts_rule_mon.sv
module sts_rule_mon
  import sts_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sts_state_e   state,
  input  logic [N-1:0] oe,
  input  logic [N-1:0] assert_req,
  output logic         idle_err,
  output logic         rogue_err
);
  logic in_gap;

  assign in_gap = (state == ST_DEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_err  <= 1'b0;
      rogue_err <= 1'b0;
    end else begin
      idle_err  <= in_gap && (|assert_req);
      rogue_err <= !in_gap && (|(assert_req & ~oe));
    end
  end
endmodule

// File: rtl/sts_owner_ctl.sv
module sts_owner_ctl
  import sts_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ID_W     = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                claim_valid,
  input  logic [ID_W-1:0]     claim_id,
  output logic                claim_ready,
  input  logic [N_AGENTS-1:0] assert_req,
  input  logic [N_AGENTS-1:0] release_req,
  output logic [N_AGENTS-1:0] oe_o,
  output logic [N_AGENTS-1:0] val_o,
  output logic                line_o,
  output logic                contention_o,
  output logic                idle_err_o,
  output logic                rogue_err_o
);
  sts_state_e      state;
  logic [ID_W-1:0] owner;
  logic            drive_low;

  sts_hand_fsm #(.N(N_AGENTS), .IDW(ID_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim_valid (claim_valid),
    .claim_id    (claim_id),
    .assert_req  (assert_req),
    .release_req (release_req),
    .state       (state),
    .owner       (owner),
    .drive_low   (drive_low),
    .claim_ready (claim_ready)
  );

  sts_drive_fanout #(.N(N_AGENTS), .IDW(ID_W)) u_fan (
    .state     (state),
    .owner     (owner),
    .drive_low (drive_low),
    .oe        (oe_o),
    .val       (val_o)
  );

  sts_line_resolve #(.N(N_AGENTS)) u_res (
    .oe         (oe_o),
    .val        (val_o),
    .line       (line_o),
    .contention (contention_o)
  );

  sts_rule_mon #(.N(N_AGENTS)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .oe         (oe_o),
    .assert_req (assert_req),
    .idle_err   (idle_err_o),
    .rogue_err  (rogue_err_o)
  );
endmodule

// File: rtl/sts_own_chk.sv
module sts_own_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] assert_req,
  input logic [N-1:0] oe_o,
  input logic         line_o,
  input logic         claim_ready,
  input logic         contention_o
);
  // R9: never more than one enabled driver
  a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe_o));

  // R9: the clash flag stays quiet
  a_r9_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !contention_o);

  // R8: undriven line is pulled high
  a_r8_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o == '0) |-> line_o);

  // R4: a low level is always followed by a driven cycle
  a_r4_high_before_float: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_o != '0) && !line_o) |=> (oe_o != '0));

  // R6: the driver cannot swap without an undriven cycle in between
  a_r6_gap_between_owners: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_o != '0) && ($past(oe_o) != '0)) |-> (oe_o == $past(oe_o)));

  // R7: no claim accepted while someone drives
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o != '0) |-> !claim_ready);

  // R3: a low line was requested on the previous edge
  a_r3_low_was_asked: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe_o != '0) && !line_o) |-> $past(|assert_req));
endmodule

bind sts_owner_ctl sts_own_chk #(.N(N_AGENTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .assert_req   (assert_req),
  .oe_o         (oe_o),
  .line_o       (line_o),
  .claim_ready  (claim_ready),
  .contention_o (contention_o)
);

// File: tb/sim_sts_owner_ctl.sv
`timescale 1ns/1ps
module sim_sts_owner_ctl;
  localparam int N    = 4;
  localparam int IDW  = 2;
  localparam int ROWS = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           claim_valid;
  logic [IDW-1:0] claim_id;
  logic           claim_ready;
  logic [N-1:0]   assert_req;
  logic [N-1:0]   release_req;
  logic [N-1:0]   oe_o;
  logic [N-1:0]   val_o;
  logic           line_o;
  logic           contention_o;
  logic           idle_err_o;
  logic           rogue_err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sts_owner_ctl #(.N_AGENTS(N)) u0 (
    .clk, .rst_n, .claim_valid, .claim_id, .claim_ready,
    .assert_req, .release_req, .oe_o, .val_o, .line_o,
    .contention_o, .idle_err_o, .rogue_err_o
  );

  // Row: {claim_valid, claim_id, assert_req, release_req,
  //       exp oe, exp line, exp ready, exp idle_err, exp rogue_err}
  localparam logic [18:0] TBL [ROWS] = '{
    {1'b1, 2'd1, 4'b0000, 4'b0000, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 claim agent1, first cycle high
    {1'b0, 2'd0, 4'b0010, 4'b0000, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 owner pulls low
    {1'b0, 2'd0, 4'b1010, 4'b0000, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 agent3 intrudes
    {1'b0, 2'd0, 4'b0010, 4'b0010, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 release from low: park high
    {1'b1, 2'd2, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 claim while parked ignored; float
    {1'b1, 2'd2, 4'b0100, 4'b0000, 4'b0100, 1'b1, 1'b0, 1'b1, 1'b0}, // R10 R6 early low in gap; claim taken
    {1'b0, 2'd0, 4'b0000, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 release from high
    {1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 idle pull-up
    {1'b0, 2'd0, 4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R11 low request with no owner
    {1'b1, 2'd0, 4'b0000, 4'b0000, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 claim agent0
    {1'b0, 2'd0, 4'b0001, 4'b0010, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0}, // R12 foreign release ignored
    {1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 owner lets go high
    {1'b0, 2'd0, 4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 low again
    {1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 park
    {1'b1, 2'd3, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 claim during park dropped
    {1'b1, 2'd3, 4'b0000, 4'b0000, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 new owner after gap
    {1'b0, 2'd0, 4'b1000, 4'b0000, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    {1'b0, 2'd0, 4'b0000, 4'b1000, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    {1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 gap
    {1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0}  // R1-like idle
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic drive(input logic cv, input logic [IDW-1:0] cid,
                       input logic [N-1:0] as, input logic [N-1:0] rel);
    claim_valid = cv;
    claim_id    = cid;
    assert_req  = as;
    release_req = rel;
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, " R1 oe"},    32'(oe_o), 32'h0);
    chk({tag, " R1 line"},  32'(line_o), 32'h1);
    chk({tag, " R1 ready"}, 32'(claim_ready), 32'h1);
    chk({tag, " R1 errs"},  32'({contention_o, idle_err_o, rogue_err_o}), 32'h0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    drive(1'b0, '0, '0, '0);
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check_reset_state("reset");

    for (int r = 0; r < ROWS; r++) begin
      logic [18:0] v;
      v = TBL[r];
      drive(v[18], v[17:16], v[15:12], v[11:8]);
      tick();
      chk($sformatf("row%0d R2/R6 oe", r),      32'(oe_o), 32'(v[7:4]));
      chk($sformatf("row%0d R8 line", r),       32'(line_o), 32'(v[3]));
      chk($sformatf("row%0d R7 ready", r),      32'(claim_ready), 32'(v[2]));
      chk($sformatf("row%0d R10 idle_err", r),  32'(idle_err_o), 32'(v[1]));
      chk($sformatf("row%0d R11 rogue_err", r), 32'(rogue_err_o), 32'(v[0]));
      chk($sformatf("row%0d R9 contention", r), 32'(contention_o), 32'h0);
    end

    // R1: reset in the middle of a low drive returns to the quiet state
    drive(1'b1, 2'd2, '0, '0);
    tick();
    drive(1'b0, '0, 4'b0100, '0);
    tick();
    chk("mid R3 low before reset", 32'(line_o), 32'h0);
    rst_n = 1'b0;
    tick();
    check_reset_state("midreset");
    rst_n = 1'b1;
    drive(1'b0, '0, '0, '0);
    tick();
    check_reset_state("after");

    // R5: immediate release in the first owned cycle floats with no park
    drive(1'b1, 2'd1, '0, '0);
    tick();
    drive(1'b0, '0, '0, 4'b0010);
    tick();
    chk("R5 quick release oe", 32'(oe_o), 32'h0);
    chk("R5 quick release ready", 32'(claim_ready), 32'h1);

    // R12: release from the wrong agent keeps the owner enabled
    drive(1'b1, 2'd3, '0, '0);
    tick();
    drive(1'b0, '0, '0, 4'b0111);
    tick();
    chk("R12 owner kept", 32'(oe_o), 32'h8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule